// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns the system clock into the timing enables a serial port needs. In asynchronous mode it divides the clock by an integer divisor plus a fraction in eighths of a clock. It then groups 16 or 8 sample periods into one bit. The fraction is spread over the sample periods: a small accumulator lengthens some of them by one clock, so the bit period averages out exactly.

In the two clocked master modes the divisor sets the bit period directly, with no fraction. In these modes the block also drives a serial clock output. One of these modes is meant for SPI and refuses divisors below 4. In the external-clock mode the bit timing comes from a serial clock pin. That pin is brought into the system clock domain by a two-flop synchronizer, and its rising edges are detected.

A new divisor, fraction, oversampling choice or mode is picked up only at a bit boundary. While the generator is stopped it is picked up on every clock. The shift registers, the framing logic and any register interface sit outside this block.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, sample_tick, bit_tick and sck_out are all low.
- R2: In asynchronous mode (mode = 0) with cd ≥ 1, successive bit_tick pulses are OVER·cd + (OVER/8)·fp clocks apart. OVER is 16 when over8 = 0 and 8 when over8 = 1.
- R3: In asynchronous mode each bit holds exactly OVER sample_tick pulses, and the last of them coincides with bit_tick. Every gap between sample ticks is cd or cd+1 clocks. The gap is cd+1 exactly 2·fp times per bit at x16, and fp times per bit at x8.
- R4: In synchronous master mode (mode = 1) with cd ≥ 1, bit_tick repeats every cd clocks and sample_tick pulses with it. In each period sck_out is high for floor(cd/2) clocks, at the end of the period.
- R5: In SPI master mode (mode = 2), timing is as in R4 when cd ≥ 4. When cd is 1, 2 or 3, no ticks are produced and sck_out stays low.
- R6: In modes 0, 1 and 2, cd = 0 stops all tick generation.
- R7: In external-clock mode (mode = 3), each rising edge of ext_sck gives one clock cycle on which both ticks are high. That cycle comes on the second rising system clock edge after the change on ext_sck. Falling edges give no tick, and sck_out stays low.
- R8: A change of cd, fp, over8 or mode made in the middle of a bit does not alter that bit's length. The new setting governs the bit that follows.
- R9: In asynchronous mode sck_out stays low.
- R10: The divisor covers the full 16-bit range. In synchronous master mode, cd = 65535 gives a 65535-clock bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd | input | 16 | Integer divisor; 0 stops the generator |
| fp | input | 3 | Fractional divisor in eighths of a clock (asynchronous mode only) |
| over8 | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| mode | input | 2 | 0 asynchronous, 1 synchronous master, 2 SPI master, 3 external clock |
| ext_sck | input | 1 | External serial clock, asynchronous to clk |
| sample_tick | output | 1 | One-cycle pulse per sample period |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| sck_out | output | 1 | Serial clock driven in the master modes |

## Verification
Divider ticks are combinational from the counter state, so all timing is measured as distances in clock cycles between tick pulses. The bench samples on falling edges and takes the interval that starts at the first bit tick after a setting is changed. Under R8 that first tick is the boundary where the new setting is loaded, and the interval after it is the first one the new setting governs. The external-clock latency is checked cycle by cycle: the tick must be low on the first falling edge after ext_sck rises, high on the second, and low again on the third.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int CD_W = 16,
  parameter int FP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CD_W-1:0] cd,
  input  logic [FP_W-1:0] fp,
  input  logic            over8,
  input  logic [1:0]      mode,
  input  logic            ext_sck,
  output logic            sample_tick,
  output logic            bit_tick,
  output logic            sck_out
);
  localparam logic [1:0] M_ASYNC = 2'd0;
  localparam logic [1:0] M_SYNC  = 2'd1;
  localparam logic [1:0] M_SPI   = 2'd2;
  localparam logic [1:0] M_EXT   = 2'd3;
  localparam int SC_W = FP_W + 1;
  localparam logic [SC_W-1:0] OV16_LIM = {SC_W{1'b1}};
  localparam logic [SC_W-1:0] OV8_LIM  = {1'b0, {FP_W{1'b1}}};
  localparam logic [CD_W-1:0] SPI_MIN  = CD_W'(4);

  logic [CD_W-1:0] cd_q, cnt, lim;
  logic [FP_W-1:0] fp_q, acc;
  logic [SC_W-1:0] scnt;
  logic [FP_W:0]   acc_sum;
  logic            over8_q;
  logic [1:0]      mode_q;
  logic            div_run, div_tick, load, extra, is_master;
  logic            s1, s2, s3, ext_rise;

  assign is_master = (mode_q == M_SYNC) || (mode_q == M_SPI);
  assign div_run   = (mode_q != M_EXT) && (cd_q != '0) &&
                     !((mode_q == M_SPI) && (cd_q < SPI_MIN));
  assign acc_sum   = {1'b0, acc} + {1'b0, fp_q};
  assign extra     = (mode_q == M_ASYNC) && acc_sum[FP_W];
  assign lim       = cd_q - CD_W'(1) + CD_W'(extra);
  assign div_tick  = div_run && (cnt == lim);
  assign ext_rise  = s2 && !s3;

  always_comb begin
    if (mode_q == M_EXT) begin
      sample_tick = ext_rise;
      bit_tick    = ext_rise;
    end else if (mode_q == M_ASYNC) begin
      sample_tick = div_tick;
      bit_tick    = div_tick && (scnt == (over8_q ? OV8_LIM : OV16_LIM));
    end else begin
      sample_tick = div_tick;
      bit_tick    = div_tick;
    end
  end

  assign sck_out = div_run && is_master && (cnt >= (cd_q - (cd_q >> 1)));
  assign load    = bit_tick || !div_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q    <= '0;
      fp_q    <= '0;
      over8_q <= 1'b0;
      mode_q  <= M_ASYNC;
    end else if (load) begin
      cd_q    <= cd;
      fp_q    <= fp;
      over8_q <= over8;
      mode_q  <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= '0;
      scnt <= '0;
    end else if (!div_run) begin
      cnt  <= '0;
      acc  <= '0;
      scnt <= '0;
    end else if (div_tick) begin
      cnt  <= '0;
      acc  <= load ? '0 : acc_sum[FP_W-1:0];
      scnt <= load ? '0 : scnt + SC_W'(1);
    end else begin
      cnt  <= cnt + CD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_sck;
      s2 <= s1;
      s3 <= s2;
    end
  end

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);                                            // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_run |-> (cnt <= cd_q));                                           // R3
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_EXT && cd_q == '0) |-> !sample_tick && !sck_out);        // R6
  AST_SPI_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SPI && cd_q < SPI_MIN) |-> !sample_tick && !sck_out);    // R5
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ASYNC || mode_q == M_EXT) |-> !sck_out);                 // R9
  AST_EXT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_EXT && bit_tick) |=> !bit_tick);                         // R7
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cd = '0;
  logic [2:0]  fp = '0;
  logic        over8 = 1'b0;
  logic [1:0]  mode = '0;
  logic        ext_sck = 1'b0;
  logic        sample_tick, bit_tick, sck_out;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .cd(cd), .fp(fp), .over8(over8), .mode(mode),
    .ext_sck(ext_sck), .sample_tick(sample_tick), .bit_tick(bit_tick),
    .sck_out(sck_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bit(input int limit, output bit found);
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (bit_tick) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure(input int cdv, input int limit,
                         output int blen, output int samp, output int longs,
                         output int odd, output int highs);
    bit f;
    int t1, ls;
    blen = -1; samp = 0; longs = 0; odd = 0; highs = 0;
    wait_bit(limit, f);
    if (!f) return;
    t1 = cyc; ls = cyc;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sck_out) highs++;
      if (sample_tick) begin
        samp++;
        if (cyc - ls == cdv + 1) longs++;
        else if (cyc - ls != cdv) odd++;
        ls = cyc;
      end
      if (bit_tick) begin
        blen = cyc - t1;
        break;
      end
    end
  endtask

  task automatic count_ticks(input int n, output int ticks, output int highs);
    ticks = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) ticks++;
      if (sck_out) highs++;
    end
  endtask

  initial begin
    int bl, sp, lg, od, hi, ov, tk, t0;
    bit f;
    repeat (3) @(negedge clk);
    chk(!sample_tick && !bit_tick && !sck_out, "R1", {sample_tick, bit_tick, sck_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    count_ticks(50, tk, hi);
    chk(tk == 0 && hi == 0, "R6 cd=0 async", tk, 0);

    for (int o = 0; o < 2; o++) begin
      for (int ci = 0; ci < 4; ci++) begin
        for (int f8 = 0; f8 < 8; f8++) begin
          int cv;
          cv = (ci == 3) ? 5 : ci + 1;
          mode = 2'd0; over8 = o[0]; cd = 16'(cv); fp = 3'(f8);
          ov = o ? 8 : 16;
          measure(cv, 400, bl, sp, lg, od, hi);
          chk(bl == ov * cv + (ov / 8) * f8, "R2 async bit period", bl, ov * cv + (ov / 8) * f8);
          chk(sp == ov && od == 0, "R3 samples per bit", sp, ov);
          chk(lg == (ov / 8) * f8, "R3 long sample gaps", lg, (ov / 8) * f8);
          chk(hi == 0, "R9 sck idle async", hi, 0);
        end
      end
    end

    for (int cv = 1; cv < 10; cv++) begin
      mode = 2'd1; cd = 16'(cv);
      measure(cv, 400, bl, sp, lg, od, hi);
      chk(bl == cv, "R4 sync period", bl, cv);
      chk(sp == 1, "R4 sample with bit", sp, 1);
      chk(hi == cv / 2, "R4 sck high time", hi, cv / 2);
    end

    for (int cv = 4; cv < 10; cv++) begin
      mode = 2'd2; cd = 16'(cv);
      measure(cv, 400, bl, sp, lg, od, hi);
      chk(bl == cv, "R5 spi period", bl, cv);
      chk(hi == cv / 2, "R5 spi sck high time", hi, cv / 2);
    end
    for (int cv = 1; cv < 4; cv++) begin
      mode = 2'd2; cd = 16'(cv);
      repeat (12) @(negedge clk);
      count_ticks(60, tk, hi);
      chk(tk == 0 && hi == 0, "R5 spi cd below 4", tk + hi, 0);
    end

    mode = 2'd1; cd = 16'd0;
    repeat (4) @(negedge clk);
    count_ticks(60, tk, hi);
    chk(tk == 0 && hi == 0, "R6 cd=0 sync", tk + hi, 0);

    mode = 2'd1; cd = 16'd65535;
    measure(65535, 70000, bl, sp, lg, od, hi);
    chk(bl == 65535, "R10 max divisor", bl, 65535);

    mode = 2'd0; over8 = 1'b0; fp = 3'd0; cd = 16'd200;
    wait_bit(70000, f);
    wait_bit(4000, f);
    t0 = cyc;
    repeat (100) @(negedge clk);
    cd = 16'd1; fp = 3'd3; over8 = 1'b1;
    wait_bit(4000, f);
    chk(f && cyc - t0 == 3200, "R8 old bit kept", cyc - t0, 3200);
    t0 = cyc;
    wait_bit(4000, f);
    chk(f && cyc - t0 == 11, "R8 new setting next bit", cyc - t0, 11);

    cd = 16'd0;
    repeat (30) @(negedge clk);
    mode = 2'd3;
    repeat (6) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      int a, b, c;
      ext_sck = 1'b1;
      @(negedge clk); a = bit_tick;
      @(negedge clk); b = bit_tick && sample_tick;
      @(negedge clk); c = bit_tick;
      chk(a == 0 && b == 1 && c == 0, "R7 ext rise latency", a * 4 + b * 2 + c, 2);
      repeat (p + 2) @(negedge clk);
      ext_sck = 1'b0;
      count_ticks(6, tk, hi);
      chk(tk == 0 && hi == 0, "R7 falling edge no tick", tk + hi, 0);
    end
    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 190000);
    if (!done) chk(1'b0, "watchdog", cyc, 190000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule